// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the architectural state update a pipelined core makes when it takes an exception. The pipeline presents a vector of fault requests together with the faulting PC, a delay-slot flag, the faulting virtual address, the address-space identifier and a coprocessor number. The block picks the most urgent request and updates its control registers. It then issues a one-cycle redirect carrying the handler address and the two fetch addresses that follow it.

The block holds the machine-mode register, the cause register, the return PC, the faulting address, the vector base, the register-set control word, the translation tag and the page-walk context. A simple write port lets the core load any of them. Reset, whether from the reset pin or from the soft-reset request, redirects fetch to a fixed boot address.

Control is a three-state machine. `ST_RESET` drives the boot redirect and always moves to `ST_RUN`. `ST_RUN` waits for requests: a soft reset moves it to `ST_RESET`, any other accepted request moves it to `ST_ENTRY`, and with no request it stays in `ST_RUN`. `ST_ENTRY` drives the handler redirect and always returns to `ST_RUN`.

Top module: `exc_entry_unit`

## Requirements
- R1: While the reset pin is low, and for the first cycle after it is released, `redirect_valid` is 1 and `handler_pc` is 0xBFC00000. `mode_q` is 0x20400000, meaning cop1-usable (bit 29) and boot-vector (bit 22) are set and the exception-level bit 1 is clear. `vec_base_q` is 0x80000000 and every other register is 0.
- R2: Simultaneous requests are resolved by the lowest `fault_req` index. The indices are: 0 soft reset, 1 load/fetch address error, 2 store address error, 3 load/fetch refill, 4 store refill, 5 load/fetch invalid, 6 store invalid, 7 modified, 8 interrupt, 9 system call, 10 breakpoint, 11 reserved instruction, 12 coprocessor unusable, 13 overflow, 14 trap.
- R3: Each accepted request produces exactly one cycle of `redirect_valid`, in the cycle after the request is sampled. Requests present during that redirect cycle are ignored.
- R4: `cause_q[6:2]` receives the code for the accepted request: index 1→4, 2→5, 3 and 5→2, 4 and 6→3, 7→1, 8→0, 9→8, 10→9, 11→0xA, 12→0xB, 13→0xC, 14→0xD.
- R5: Every non-reset entry sets `mode_q` bit 1, even if it was already set.
- R6: The register-set control word holds the current set in [3:0], the previous set in [9:6] and the exception set in [15:12]. Only when mode bits 1 and 22 were both clear before entry does previous take current and current take the exception set; otherwise the word is unchanged.
- R7: With `fault_in_dslot` set, `ret_pc_q` is `fault_pc`−4 and `cause_q[31]` is 1. Otherwise `ret_pc_q` is `fault_pc` and `cause_q[31]` is 0.
- R8: `cause_q[29:28]` receives `fault_cop` on a coprocessor-unusable entry and 0 on every other entry.
- R9: The default handler is `vec_base_q`+0x180. During the redirect cycle `fetch_pc1` is the handler plus 4 and `fetch_pc2` is the handler plus 8.
- R10: A refill (index 3 or 4) goes to `vec_base_q`+0x000 when mode bit 1 was clear before entry, and to +0x180 when it was set.
- R11: An interrupt goes to `vec_base_q`+0x200 when `cause_q` bit 23 is set, and to +0x180 otherwise. Bit 23 is kept through entry.
- R12: An overflow taken with mode bit 22 set goes to 0xBFC00200.
- R13: Translation faults (indices 3 to 7) load `fault_addr_q` with the address. They load `tlb_tag_q[31:13]` with address bits 31:13 and `tlb_tag_q[7:0]` with `fault_asid`, and they load `walk_ctx_q[22:4]` with address bits 31:13. Address errors load `fault_addr_q` only.
- R14: `csr_wr_sel` selects the target of a write: 0 mode, 1 cause, 2 return PC, 3 fault address, 4 vector base (low 12 bits forced to 0), 5 set control, 6 tag, 7 context. An accepted request in the same cycle wins and drops the write. A soft reset sets mode bits 29 and 22 and redirects to 0xBFC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_req | input | 15 | Fault request vector, one bit per source |
| fault_pc | input | 32 | PC of the faulting instruction |
| fault_in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| fault_vaddr | input | 32 | Faulting virtual address |
| fault_asid | input | 8 | Address-space identifier of the access |
| fault_cop | input | 2 | Coprocessor number for unusable faults |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_sel | input | 3 | Register write target |
| csr_wr_data | input | 32 | Register write data |
| redirect_valid | output | 1 | Fetch redirect strobe |
| handler_pc | output | 32 | Redirect target |
| fetch_pc1 | output | 32 | Second fetch address |
| fetch_pc2 | output | 32 | Third fetch address |
| mode_q | output | 32 | Machine-mode register |
| cause_q | output | 32 | Cause register |
| ret_pc_q | output | 32 | Return PC |
| fault_addr_q | output | 32 | Captured faulting address |
| vec_base_q | output | 32 | Vector base |
| shadow_ctl_q | output | 32 | Register-set control word |
| tlb_tag_q | output | 32 | Translation tag |
| walk_ctx_q | output | 32 | Page-walk context |

## Verification
The vector choice is driven with refills under both values of the prior exception level, interrupts with the vector-select bit set and clear, and overflow with boot mode set against ordinary faults. Together these separate a vector that samples state before entry from one that samples it after. The set-swap and delay-slot paths each get a case where the update fires and a case where it must not. Multi-bit request patterns show whether the lowest index wins. A write that collides with an entry, and a request held into the redirect cycle, show that both are dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN    = 32;
    localparam int NUM_SRC = 15;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int CODE_W  = 5;
    localparam int COP_W   = 2;
    localparam int ASID_W  = 8;
    localparam int SET_W   = 4;

    // source indices (order is the priority)
    localparam int SRC_SRESET      = 0;
    localparam int SRC_ADDR_LD     = 1;
    localparam int SRC_ADDR_ST     = 2;
    localparam int SRC_REFILL_LD   = 3;
    localparam int SRC_REFILL_ST   = 4;
    localparam int SRC_INVALID_LD  = 5;
    localparam int SRC_INVALID_ST  = 6;
    localparam int SRC_MODIFIED    = 7;
    localparam int SRC_IRQ         = 8;
    localparam int SRC_SYSCALL     = 9;
    localparam int SRC_BREAK       = 10;
    localparam int SRC_RESERVED    = 11;
    localparam int SRC_COP_UNUSE   = 12;
    localparam int SRC_OVERFLOW    = 13;
    localparam int SRC_TRAP        = 14;

    // register field positions
    localparam int MODE_LVL     = 1;
    localparam int MODE_BOOT    = 22;
    localparam int MODE_COP1    = 29;
    localparam int CAUSE_CODE   = 2;
    localparam int CAUSE_IRQSEL = 23;
    localparam int CAUSE_COP    = 28;
    localparam int CAUSE_DSLOT  = 31;
    localparam int SH_CUR       = 0;
    localparam int SH_PREV      = 6;
    localparam int SH_EXC       = 12;
    localparam int TAG_VPN      = 13;
    localparam int CTX_VPN      = 4;
    localparam int VPN_W        = XLEN - TAG_VPN;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_ENTRY = 2'd2
    } entry_state_e;

    typedef enum logic [2:0] {
        SEL_MODE   = 3'd0,
        SEL_CAUSE  = 3'd1,
        SEL_RETPC  = 3'd2,
        SEL_FADDR  = 3'd3,
        SEL_VBASE  = 3'd4,
        SEL_SHADOW = 3'd5,
        SEL_TAG    = 3'd6,
        SEL_CTX    = 3'd7
    } csr_sel_e;

    function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
        logic [CODE_W-1:0] c;
        unique case (int'(idx))
            SRC_ADDR_LD:                   c = 5'h4;
            SRC_ADDR_ST:                   c = 5'h5;
            SRC_REFILL_LD, SRC_INVALID_LD: c = 5'h2;
            SRC_REFILL_ST, SRC_INVALID_ST: c = 5'h3;
            SRC_MODIFIED:                  c = 5'h1;
            SRC_SYSCALL:                   c = 5'h8;
            SRC_BREAK:                     c = 5'h9;
            SRC_RESERVED:                  c = 5'hA;
            SRC_COP_UNUSE:                 c = 5'hB;
            SRC_OVERFLOW:                  c = 5'hC;
            SRC_TRAP:                      c = 5'hD;
            default:                       c = 5'h0;
        endcase
        return c;
    endfunction

    function automatic logic src_is_xlate(input logic [IDX_W-1:0] idx);
        return (int'(idx) >= SRC_REFILL_LD) && (int'(idx) <= SRC_MODIFIED);
    endfunction

    function automatic logic src_is_addr(input logic [IDX_W-1:0] idx);
        return (int'(idx) == SRC_ADDR_LD) || (int'(idx) == SRC_ADDR_ST);
    endfunction

    function automatic logic src_is_refill(input logic [IDX_W-1:0] idx);
        return (int'(idx) == SRC_REFILL_LD) || (int'(idx) == SRC_REFILL_ST);
    endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
    parameter int N     = 15,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [N-1:0] grant;

    for (genvar g = 0; g < N; g++) begin : g_mask
        if (g == 0) begin : g_first
            assign grant[g] = req_i[0];
        end else begin : g_rest
            assign grant[g] = req_i[g] & ~(|req_i[g-1:0]);
        end
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] OFS_GENERAL = 32'h0000_0180,
    parameter logic [XLEN-1:0] OFS_IRQ     = 32'h0000_0200,
    parameter logic [XLEN-1:0] OFS_REFILL  = 32'h0000_0000,
    parameter logic [XLEN-1:0] BOOT_OVF    = 32'hBFC0_0200
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [XLEN-1:0]  base_i,
    input  logic             lvl_old_i,
    input  logic             boot_i,
    input  logic             irq_sel_i,
    output logic [XLEN-1:0]  vec_o
);

    always_comb begin
        if ((int'(idx_i) == SRC_OVERFLOW) && boot_i) begin
            vec_o = BOOT_OVF;
        end else if (src_is_refill(idx_i)) begin
            // level must be the value held before this entry
            vec_o = base_i + (lvl_old_i ? OFS_GENERAL : OFS_REFILL);
        end else if (int'(idx_i) == SRC_IRQ) begin
            vec_o = base_i + (irq_sel_i ? OFS_IRQ : OFS_GENERAL);
        end else begin
            vec_o = base_i + OFS_GENERAL;
        end
    end

endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] VBASE_RST = 32'h8000_0000,
    parameter int              VBASE_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              dslot_i,
    input  logic [XLEN-1:0]   vaddr_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [COP_W-1:0]  cop_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [XLEN-1:0]   wr_data_i,
    output logic [XLEN-1:0]   mode_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   ret_pc_o,
    output logic [XLEN-1:0]   faddr_o,
    output logic [XLEN-1:0]   vbase_o,
    output logic [XLEN-1:0]   shadow_o,
    output logic [XLEN-1:0]   tag_o,
    output logic [XLEN-1:0]   ctx_o
);

    localparam logic [XLEN-1:0] VBASE_MASK = ~((XLEN'(1) << VBASE_LSB) - XLEN'(1));
    localparam logic [XLEN-1:0] MODE_RST   = (XLEN'(1) << MODE_COP1) | (XLEN'(1) << MODE_BOOT);

    logic sreset;
    logic may_swap;
    assign sreset   = (int'(idx_i) == SRC_SRESET);
    assign may_swap = !mode_o[MODE_LVL] && !mode_o[MODE_BOOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o   <= MODE_RST;
            cause_o  <= '0;
            ret_pc_o <= '0;
            faddr_o  <= '0;
            vbase_o  <= VBASE_RST & VBASE_MASK;
            shadow_o <= '0;
            tag_o    <= '0;
            ctx_o    <= '0;
        end else if (take_i) begin
            if (sreset) begin
                mode_o[MODE_COP1] <= 1'b1;
                mode_o[MODE_BOOT] <= 1'b1;
            end else begin
                mode_o[MODE_LVL] <= 1'b1;
                if (may_swap) begin
                    shadow_o[SH_PREV +: SET_W] <= shadow_o[SH_CUR +: SET_W];
                    shadow_o[SH_CUR  +: SET_W] <= shadow_o[SH_EXC +: SET_W];
                end
                ret_pc_o                   <= dslot_i ? (pc_i - XLEN'(4)) : pc_i;
                cause_o[CAUSE_DSLOT]       <= dslot_i;
                cause_o[CAUSE_CODE +: CODE_W] <= src_code(idx_i);
                cause_o[CAUSE_COP +: COP_W] <= (int'(idx_i) == SRC_COP_UNUSE) ? cop_i : '0;
                if (src_is_xlate(idx_i) || src_is_addr(idx_i)) begin
                    faddr_o <= vaddr_i;
                end
                if (src_is_xlate(idx_i)) begin
                    tag_o[TAG_VPN +: VPN_W]  <= vaddr_i[XLEN-1:TAG_VPN];
                    tag_o[ASID_W-1:0]        <= asid_i;
                    ctx_o[CTX_VPN +: VPN_W]  <= vaddr_i[XLEN-1:TAG_VPN];
                end
            end
        end else if (wr_en_i) begin
            unique case (csr_sel_e'(wr_sel_i))
                SEL_MODE:   mode_o   <= wr_data_i;
                SEL_CAUSE:  cause_o  <= wr_data_i;
                SEL_RETPC:  ret_pc_o <= wr_data_i;
                SEL_FADDR:  faddr_o  <= wr_data_i;
                SEL_VBASE:  vbase_o  <= wr_data_i & VBASE_MASK;
                SEL_SHADOW: shadow_o <= wr_data_i;
                SEL_TAG:    tag_o    <= wr_data_i;
                SEL_CTX:    ctx_o    <= wr_data_i;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] VBASE_RST = 32'h8000_0000,
    parameter int              INSN_B    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   fault_req,
    input  logic [XLEN-1:0]      fault_pc,
    input  logic                 fault_in_dslot,
    input  logic [XLEN-1:0]      fault_vaddr,
    input  logic [ASID_W-1:0]    fault_asid,
    input  logic [COP_W-1:0]     fault_cop,
    input  logic                 csr_wr_en,
    input  logic [2:0]           csr_wr_sel,
    input  logic [XLEN-1:0]      csr_wr_data,
    output logic                 redirect_valid,
    output logic [XLEN-1:0]      handler_pc,
    output logic [XLEN-1:0]      fetch_pc1,
    output logic [XLEN-1:0]      fetch_pc2,
    output logic [XLEN-1:0]      mode_q,
    output logic [XLEN-1:0]      cause_q,
    output logic [XLEN-1:0]      ret_pc_q,
    output logic [XLEN-1:0]      fault_addr_q,
    output logic [XLEN-1:0]      vec_base_q,
    output logic [XLEN-1:0]      shadow_ctl_q,
    output logic [XLEN-1:0]      tlb_tag_q,
    output logic [XLEN-1:0]      walk_ctx_q
);

    localparam logic [XLEN-1:0] STEP1 = XLEN'(INSN_B);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_B);

    entry_state_e      state_q, state_d;
    logic              req_any;
    logic [IDX_W-1:0]  req_idx;
    logic              take;
    logic              take_sreset;
    logic [XLEN-1:0]   vec_sel;
    logic [XLEN-1:0]   handler_q;

    exc_prio_sel #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .req_i (fault_req),
        .any_o (req_any),
        .idx_o (req_idx)
    );

    assign take        = (state_q == ST_RUN) && req_any;
    assign take_sreset = take && (int'(req_idx) == SRC_SRESET);

    exc_vector_calc u_vec (
        .idx_i     (req_idx),
        .base_i    (vec_base_q),
        .lvl_old_i (mode_q[MODE_LVL]),
        .boot_i    (mode_q[MODE_BOOT]),
        .irq_sel_i (cause_q[CAUSE_IRQSEL]),
        .vec_o     (vec_sel)
    );

    exc_csr_file #(.VBASE_RST(VBASE_RST)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .idx_i     (req_idx),
        .pc_i      (fault_pc),
        .dslot_i   (fault_in_dslot),
        .vaddr_i   (fault_vaddr),
        .asid_i    (fault_asid),
        .cop_i     (fault_cop),
        .wr_en_i   (csr_wr_en),
        .wr_sel_i  (csr_wr_sel),
        .wr_data_i (csr_wr_data),
        .mode_o    (mode_q),
        .cause_o   (cause_q),
        .ret_pc_o  (ret_pc_q),
        .faddr_o   (fault_addr_q),
        .vbase_o   (vec_base_q),
        .shadow_o  (shadow_ctl_q),
        .tag_o     (tlb_tag_q),
        .ctx_o     (walk_ctx_q)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_RUN;
            ST_RUN: begin
                if (take_sreset)  state_d = ST_RESET;
                else if (take)    state_d = ST_ENTRY;
            end
            ST_ENTRY: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // handler capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     handler_q <= '0;
        else if (take && !take_sreset)  handler_q <= vec_sel;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RESET: begin
                redirect_valid = 1'b1;
                handler_pc     = RESET_VEC;
            end
            ST_ENTRY: begin
                redirect_valid = 1'b1;
                handler_pc     = handler_q;
            end
            default: begin
                redirect_valid = 1'b0;
                handler_pc     = handler_q;
            end
        endcase
        fetch_pc1 = handler_pc + STEP1;
        fetch_pc2 = handler_pc + STEP2;
    end

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            entry_now,
    input logic            boot_now,
    input logic            redirect_valid,
    input logic [XLEN-1:0] mode_q,
    input logic [XLEN-1:0] cause_q,
    input logic [XLEN-1:0] ret_pc_q,
    input logic [XLEN-1:0] fault_pc,
    input logic            fault_in_dslot
);

    assert_redirect_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    assert_level_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_now |-> mode_q[1]);

    assert_ret_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_now |-> (ret_pc_q == ($past(fault_in_dslot) ? ($past(fault_pc) - 32'd4) : $past(fault_pc))));

    assert_dslot_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_now |-> (cause_q[31] == $past(fault_in_dslot)));

    assert_boot_mode_R14: assert property (@(posedge clk) disable iff (!rst_n)
        boot_now |-> (mode_q[29] && mode_q[22] && redirect_valid));

endmodule

bind exc_entry_unit exc_entry_checker #(.XLEN(exc_entry_pkg::XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .entry_now      (state_q == exc_entry_pkg::ST_ENTRY),
    .boot_now       (state_q == exc_entry_pkg::ST_RESET),
    .redirect_valid (redirect_valid),
    .mode_q         (mode_q),
    .cause_q        (cause_q),
    .ret_pc_q       (ret_pc_q),
    .fault_pc       (fault_pc),
    .fault_in_dslot (fault_in_dslot)
);

// File: tb/exc_entry_unit_test.sv
`timescale 1ns/1ps
module exc_entry_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] fault_req = '0;
    logic [31:0] fault_pc = '0;
    logic        fault_in_dslot = 1'b0;
    logic [31:0] fault_vaddr = '0;
    logic [7:0]  fault_asid = '0;
    logic [1:0]  fault_cop = '0;
    logic        csr_wr_en = 1'b0;
    logic [2:0]  csr_wr_sel = '0;
    logic [31:0] csr_wr_data = '0;
    logic        redirect_valid;
    logic [31:0] handler_pc, fetch_pc1, fetch_pc2;
    logic [31:0] mode_q, cause_q, ret_pc_q, fault_addr_q, vec_base_q;
    logic [31:0] shadow_ctl_q, tlb_tag_q, walk_ctx_q;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    exc_entry_unit uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        csr_wr_en = 1'b1; csr_wr_sel = sel; csr_wr_data = data;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    // drives one request; returns during the redirect cycle
    task automatic fire(input int src, input logic [31:0] pc, input logic ds,
                        input logic [31:0] va, input logic [7:0] asid, input logic [1:0] cop);
        @(negedge clk);
        fault_req = 15'(1) << src;
        fault_pc = pc; fault_in_dslot = ds; fault_vaddr = va;
        fault_asid = asid; fault_cop = cop;
        @(negedge clk);
        fault_req = '0;
    endtask

    function automatic logic [4:0] code_of(input logic [31:0] c);
        return c[6:2];
    endfunction

    task automatic t_reset;
        chk("R1 redirect in reset", {31'd0, redirect_valid}, 32'd1);
        chk("R1 boot vector", handler_pc, 32'hBFC00000);
        @(negedge clk); rst_n = 1'b1;
        chk("R1 redirect first cycle", {31'd0, redirect_valid}, 32'd1);
        chk("R1 mode reset", mode_q, 32'h20400000);
        chk("R1 base reset", vec_base_q, 32'h80000000);
        chk("R1 cause reset", cause_q, 32'h0);
        @(negedge clk);
        chk("R3 redirect dropped", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic t_general_and_shadow;
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h3001);
        fire(9, 32'h1000, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R9 general vector", handler_pc, 32'h80000180);
        chk("R9 fetch plus 4", fetch_pc1, 32'h80000184);
        chk("R9 fetch plus 8", fetch_pc2, 32'h80000188);
        chk("R4 syscall code", {27'd0, code_of(cause_q)}, 32'h8);
        chk("R5 level set", mode_q, 32'h2);
        chk("R7 return pc", ret_pc_q, 32'h1000);
        chk("R6 set swap", shadow_ctl_q, 32'h3043);
        chk("R3 redirect high", {31'd0, redirect_valid}, 32'd1);
        @(negedge clk);
        chk("R3 one cycle", {31'd0, redirect_valid}, 32'd0);
        fire(10, 32'h1100, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R6 no swap at level", shadow_ctl_q, 32'h3043);
        chk("R5 level kept", {31'd0, mode_q[1]}, 32'd1);
        chk("R4 break code", {27'd0, code_of(cause_q)}, 32'h9);
        @(negedge clk);
    endtask

    task automatic t_refill;
        logic [31:0] va;
        va = 32'h12346ABC;
        wr(3'd0, 32'h0);
        wr(3'd7, 32'hFF800000);
        fire(3, 32'h2000, 1'b0, va, 8'h5A, 2'd0);
        chk("R10 refill level clear", handler_pc, 32'h80000000);
        chk("R4 refill load code", {27'd0, code_of(cause_q)}, 32'h2);
        chk("R13 fault addr", fault_addr_q, va);
        chk("R13 tag", tlb_tag_q, (va & 32'hFFFFE000) | 32'h5A);
        chk("R13 context", walk_ctx_q, 32'hFF800000 | ((va >> 13) << 4));
        @(negedge clk);
        fire(4, 32'h2004, 1'b0, va, 8'h5A, 2'd0);
        chk("R10 refill level set", handler_pc, 32'h80000180);
        chk("R4 refill store code", {27'd0, code_of(cause_q)}, 32'h3);
        @(negedge clk);
        fire(2, 32'h2008, 1'b0, 32'hDEAD0003, 8'h11, 2'd0);
        chk("R13 addr error fault addr", fault_addr_q, 32'hDEAD0003);
        chk("R13 addr error tag kept", tlb_tag_q, (va & 32'hFFFFE000) | 32'h5A);
        chk("R4 store addr code", {27'd0, code_of(cause_q)}, 32'h5);
        @(negedge clk);
    endtask

    task automatic t_irq;
        wr(3'd1, 32'h00800000);
        fire(8, 32'h3000, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R11 irq vector sel", handler_pc, 32'h80000200);
        chk("R11 cause kept", cause_q, 32'h00800000);
        @(negedge clk);
        wr(3'd1, 32'h0);
        fire(8, 32'h3000, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R11 irq general", handler_pc, 32'h80000180);
        @(negedge clk);
    endtask

    task automatic t_overflow_boot;
        wr(3'd0, 32'h00400000);
        wr(3'd5, 32'h2001);
        fire(13, 32'h4000, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R12 boot overflow", handler_pc, 32'hBFC00200);
        chk("R4 overflow code", {27'd0, code_of(cause_q)}, 32'hC);
        chk("R6 no swap in boot", shadow_ctl_q, 32'h2001);
        @(negedge clk);
        fire(14, 32'h4000, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R12 trap not fixed", handler_pc, 32'h80000180);
        @(negedge clk);
    endtask

    task automatic t_cop_dslot;
        fire(12, 32'h5000, 1'b0, 32'h0, 8'h0, 2'd2);
        chk("R8 cop id loaded", cause_q, 32'h2000002C);
        @(negedge clk);
        fire(14, 32'h2000, 1'b1, 32'h0, 8'h0, 2'd3);
        chk("R7 dslot return pc", ret_pc_q, 32'h1FFC);
        chk("R8 cop id cleared", {30'd0, cause_q[29:28]}, 32'd0);
        chk("R7 dslot flag", {31'd0, cause_q[31]}, 32'd1);
        chk("R4 trap code", {27'd0, code_of(cause_q)}, 32'hD);
        @(negedge clk);
    endtask

    task automatic t_priority;
        @(negedge clk);
        fault_req = 15'h020A;
        @(negedge clk); fault_req = '0;
        chk("R2 addr error wins", {27'd0, code_of(cause_q)}, 32'h4);
        @(negedge clk);
        fault_req = 15'h2218;
        @(negedge clk); fault_req = '0;
        chk("R2 refill wins", {27'd0, code_of(cause_q)}, 32'h2);
        @(negedge clk);
        fault_req = 15'h2200;
        @(negedge clk); fault_req = '0;
        chk("R2 syscall wins", {27'd0, code_of(cause_q)}, 32'h8);
        @(negedge clk);
    endtask

    task automatic t_ignore_and_collide;
        @(negedge clk);
        fault_req = 15'(1) << 9;
        @(negedge clk);
        fault_req = 15'(1) << 11;
        chk("R3 redirect on entry", {31'd0, redirect_valid}, 32'd1);
        @(negedge clk);
        fault_req = '0;
        chk("R3 held request ignored", {31'd0, redirect_valid}, 32'd0);
        chk("R3 code unchanged", {27'd0, code_of(cause_q)}, 32'h8);
        @(negedge clk);
        fault_req = 15'(1) << 9; fault_pc = 32'h6000; fault_in_dslot = 1'b0;
        csr_wr_en = 1'b1; csr_wr_sel = 3'd2; csr_wr_data = 32'h5555;
        @(negedge clk);
        fault_req = '0; csr_wr_en = 1'b0;
        chk("R14 entry beats write", ret_pc_q, 32'h6000);
        @(negedge clk);
        wr(3'd4, 32'h90001234);
        chk("R14 base masked", vec_base_q, 32'h90001000);
        fire(9, 32'h7000, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R9 new base vector", handler_pc, 32'h90001180);
        @(negedge clk);
    endtask

    task automatic t_soft_reset;
        wr(3'd0, 32'h0);
        fire(0, 32'h0, 1'b0, 32'h0, 8'h0, 2'd0);
        chk("R14 soft reset redirect", {31'd0, redirect_valid}, 32'd1);
        chk("R14 soft reset vector", handler_pc, 32'hBFC00000);
        chk("R14 soft reset mode", mode_q, 32'h20400000);
        @(negedge clk);
        chk("R3 soft reset one cycle", {31'd0, redirect_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_general_and_shadow();
        t_refill();
        t_irq();
        t_overflow_boot();
        t_cop_dslot();
        t_priority();
        t_ignore_and_collide();
        t_soft_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule